// File: doc/BRIEF.md
# Tearing Effect Sync Detector

This block watches one tearing-effect line from a display panel. The panel sends both its vertical and its horizontal sync on that one line. The two are told apart by how long each pulse stays active. The block measures each pulse's active width in ticks of a programmable clock divider. Using two width thresholds, it classes the pulse as a vertical sync, a horizontal sync, or noise.

The active level of each sync kind can be inverted on its own. After a vertical sync, the block counts horizontal syncs as display lines. It emits a one-cycle match pulse that releases a pending frame transfer, for example through an interrupt or the start input of a transfer engine. A mode field selects what produces that pulse:

- sync off,
- vertical sync only,
- vertical sync or the arrival at a target line.

Top module: `te_sync_detect`

## Requirements
- R1: `match_o` is 0 during reset and after it, and each match is high for exactly one clock cycle.
- R2: `te_i` passes through two synchroniser flops. With a divider of 1, `match_o` is high in the cycle after the third rising clock edge that samples the trailing level of a qualifying pulse. It is low at the sampled point after the second and after the fourth such edge.
- R3: A pulse is a vertical sync when its active width in ticks is at least (`vs_thr_i`+1)*8. One tick shorter does not count as a vertical sync.
- R4: A pulse is a horizontal sync when its width is at least `hs_thr_i`+1 ticks and below the vertical threshold. Shorter pulses are ignored.
- R5: `hs_inv_i` and `vs_inv_i` make the horizontal and vertical detection active-low (0 = active-high).
- R6: One width tick lasts `clk_div_i`+1 clock cycles.
- R7: With `mode_i`=3, only vertical syncs produce a match.
- R8: With `mode_i`=2, a vertical sync produces a match and clears the line count to 0. Each later horizontal sync adds 1 to the count. When the count becomes equal to `line_tgt_i`, one match is produced, and it is produced only once until the next vertical sync, even when the count saturates at the target.
- R9: With `mode_i` equal to 0 or 1, or with `det_en_i` at 0, no match is produced and the line state is cleared.
- R10: With `mode_i`=2 and `line_tgt_i`=0, a vertical sync produces exactly one match pulse.
- R11: A line match needs a vertical sync to have been seen since reset or since sync was last switched off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| te_i | input | 1 | Tearing-effect line from the panel (asynchronous) |
| det_en_i | input | 1 | Enables the detection logic |
| mode_i | input | 2 | 0/1 off, 2 vertical or line, 3 vertical only |
| clk_div_i | input | 3 | Tick length minus one, in clock cycles |
| hs_thr_i | input | 3 | Horizontal width threshold in ticks, minus one |
| vs_thr_i | input | 9 | Vertical width threshold in units of 8 ticks, minus one |
| hs_inv_i | input | 1 | Horizontal sync active low |
| vs_inv_i | input | 1 | Vertical sync active low |
| line_tgt_i | input | 11 | Target line number for mode 2 |
| match_o | output | 1 | One-cycle match pulse |

## Verification
In line mode, a vertical sync and a line-target hit can fall on the same pulse end when the target is line 0. A vertical sync clears the count to 0, so the vertical match and a target-equals-count condition coincide. The bench provokes this with target 0 and a vertical pulse of exactly threshold width. It then judges that a single match results and that the following horizontal syncs add none. A second case is a target equal to the saturated count. Extra horizontal syncs keep hitting the target there, and the bench checks that no repeat match occurs.

// File: rtl/te_pkg.sv
package te_pkg;
  typedef enum logic [1:0] {
    TE_OFF   = 2'd0,
    TE_RSVD  = 2'd1,
    TE_LINE  = 2'd2,
    TE_VONLY = 2'd3
  } te_mode_e;

  localparam int unsigned VS_UNIT_LOG2 = 3;
  localparam int unsigned N_CHAN       = 2;  // 0: horizontal, 1: vertical
endpackage

// File: rtl/te_sync2.sv
module te_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/te_prescale.sv
module te_prescale #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the period bounded if div_i drops below the running count
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/te_width_meas.sv
module te_width_meas #(
  parameter int unsigned WID_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             tick_i,
  output logic             end_o,
  output logic [WID_W-1:0] width_o
);
  localparam logic [WID_W-1:0] WID_MAX = '1;

  logic             act_q;
  logic [WID_W-1:0] width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      width_q <= '0;
    end else begin
      act_q <= lvl_i;
      if (!lvl_i)
        width_q <= '0;
      else if (tick_i && (width_q != WID_MAX))
        width_q <= width_q + 1'b1;
    end
  end

  // trailing edge: width_q still holds the final count in this cycle
  assign end_o   = act_q & ~lvl_i;
  assign width_o = width_q;
endmodule

// File: rtl/te_line_track.sv
module te_line_track #(
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              on_i,
  input  logic              line_mode_i,
  input  logic [LINE_W-1:0] tgt_i,
  input  logic              vs_hit_i,
  input  logic              hs_hit_i,
  output logic              line_hit_o,
  output logic [LINE_W-1:0] cnt_o,
  output logic              armed_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] cnt_q, cnt_nxt;
  logic              armed_q, fired_q;

  assign cnt_nxt    = (cnt_q == LINE_MAX) ? cnt_q : cnt_q + 1'b1;
  assign line_hit_o = on_i && line_mode_i && armed_q && !fired_q &&
                      hs_hit_i && !vs_hit_i && (cnt_nxt == tgt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (!on_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (vs_hit_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      fired_q <= 1'b0;
    end else if (hs_hit_i && armed_q) begin
      cnt_q <= cnt_nxt;
      if (line_hit_o) fired_q <= 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect #(
  parameter int unsigned DIV_W    = 3,
  parameter int unsigned HS_THR_W = 3,
  parameter int unsigned VS_THR_W = 9,
  parameter int unsigned LINE_W   = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                te_i,
  input  logic                det_en_i,
  input  logic [1:0]          mode_i,
  input  logic [DIV_W-1:0]    clk_div_i,
  input  logic [HS_THR_W-1:0] hs_thr_i,
  input  logic [VS_THR_W-1:0] vs_thr_i,
  input  logic                hs_inv_i,
  input  logic                vs_inv_i,
  input  logic [LINE_W-1:0]   line_tgt_i,
  output logic                match_o
);
  import te_pkg::*;

  localparam int unsigned WID_W = VS_THR_W + VS_UNIT_LOG2 + 1;

  te_mode_e         mode;
  logic             te_s, tick, sync_on;
  logic             vs_hit, hs_hit, line_hit, match_q;
  logic [WID_W-1:0] hs_ticks, vs_ticks;
  logic [LINE_W-1:0] line_cnt;
  logic             armed;
  logic [N_CHAN-1:0]            ch_inv, ch_end;
  logic [N_CHAN-1:0][WID_W-1:0] ch_width;

  assign mode    = te_mode_e'(mode_i);
  assign sync_on = det_en_i && (mode == TE_LINE || mode == TE_VONLY);

  te_sync2 u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (te_i),
    .q_o   (te_s)
  );

  te_prescale #(.DIV_W(DIV_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (clk_div_i),
    .tick_o(tick)
  );

  assign ch_inv[0] = hs_inv_i;
  assign ch_inv[1] = vs_inv_i;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    te_width_meas #(.WID_W(WID_W)) u_meas (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (te_s ^ ch_inv[g]),
      .tick_i (tick),
      .end_o  (ch_end[g]),
      .width_o(ch_width[g])
    );
  end

  assign hs_ticks = WID_W'(hs_thr_i) + WID_W'(1);
  assign vs_ticks = (WID_W'(vs_thr_i) << VS_UNIT_LOG2) + (WID_W'(1) << VS_UNIT_LOG2);

  assign vs_hit = ch_end[1] && (ch_width[1] >= vs_ticks);
  assign hs_hit = ch_end[0] && (ch_width[0] >= hs_ticks) && (ch_width[0] < vs_ticks);

  te_line_track #(.LINE_W(LINE_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .on_i       (sync_on),
    .line_mode_i(mode == TE_LINE),
    .tgt_i      (line_tgt_i),
    .vs_hit_i   (vs_hit),
    .hs_hit_i   (hs_hit),
    .line_hit_o (line_hit),
    .cnt_o      (line_cnt),
    .armed_o    (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= sync_on && (vs_hit || line_hit);
  end

  assign match_o = match_q;
endmodule

// File: rtl/te_sync_detect_chk.sv
module te_sync_detect_chk #(
  parameter int unsigned LINE_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              det_en_i,
  input logic [1:0]        mode_i,
  input logic              match_o,
  input logic              vs_hit,
  input logic              hs_hit,
  input logic [LINE_W-1:0] line_cnt,
  input logic              armed
);
  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);  // R1

  AST_MATCH_NEEDS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ($past(det_en_i) && $past(mode_i[1])));  // R9

  AST_VONLY_FROM_VS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(mode_i) == 2'd3) |-> $past(vs_hit));  // R7

  AST_HS_VS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vs_hit && hs_hit));  // R4

  AST_LINE_CLR_ON_VS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_hit && det_en_i && mode_i[1]) |=> (line_cnt == '0));  // R8

  AST_LINE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(mode_i) == 2'd2 && !$past(vs_hit)) |-> $past(armed));  // R11
endmodule

bind te_sync_detect te_sync_detect_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .det_en_i(det_en_i),
  .mode_i  (mode_i),
  .match_o (match_o),
  .vs_hit  (vs_hit),
  .hs_hit  (hs_hit),
  .line_cnt(line_cnt),
  .armed   (armed)
);

// File: tb/te_sync_detect_tb.sv
module te_sync_detect_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic        en;
    logic [2:0]  hs_thr;
    logic [8:0]  vs_thr;
    logic [10:0] tgt;
    logic [15:0] vs_w;
    logic [15:0] hs_w;
    logic [15:0] n_hs;
    logic [3:0]  exp;
  } vec_t;

  // hs_thr 2 -> 3 ticks, vs_thr 1 -> 16 ticks, divider 1
  localparam vec_t VECS [11] = '{
    '{2'd3, 1'b1, 3'd2, 9'd1, 11'd5, 16'd20, 16'd4, 16'd8, 4'd1},  // R7
    '{2'd2, 1'b1, 3'd2, 9'd1, 11'd5, 16'd20, 16'd4, 16'd8, 4'd2},  // R8
    '{2'd2, 1'b1, 3'd2, 9'd1, 11'd9, 16'd20, 16'd4, 16'd8, 4'd1},  // R8
    '{2'd0, 1'b1, 3'd2, 9'd1, 11'd5, 16'd20, 16'd4, 16'd8, 4'd0},  // R9
    '{2'd2, 1'b0, 3'd2, 9'd1, 11'd5, 16'd20, 16'd4, 16'd8, 4'd0},  // R9
    '{2'd2, 1'b1, 3'd2, 9'd1, 11'd3, 16'd20, 16'd2, 16'd8, 4'd1},  // R4
    '{2'd2, 1'b1, 3'd2, 9'd1, 11'd3, 16'd15, 16'd4, 16'd8, 4'd0},  // R3 R11
    '{2'd2, 1'b1, 3'd2, 9'd1, 11'd0, 16'd16, 16'd4, 16'd3, 4'd1},  // R10
    '{2'd1, 1'b1, 3'd2, 9'd1, 11'd2, 16'd20, 16'd4, 16'd8, 4'd0},  // R9
    '{2'd2, 1'b1, 3'd2, 9'd1, 11'd2, 16'd20, 16'd3, 16'd4, 4'd2},  // R4
    '{2'd2, 1'b1, 3'd2, 9'd1, 11'd4, 16'd20, 16'd15, 16'd4, 4'd2}  // R4
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        te_i = 1'b0;
  logic        det_en_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [2:0]  clk_div_i = 3'd0;
  logic [2:0]  hs_thr_i = 3'd2;
  logic [8:0]  vs_thr_i = 9'd1;
  logic        hs_inv_i = 1'b0;
  logic        vs_inv_i = 1'b0;
  logic [10:0] line_tgt_i = '0;
  logic        match_o;

  int n_chk = 0, n_fail = 0, m_cnt = 0, dbl = 0;
  logic prev_m = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  te_sync_detect u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .te_i(te_i), .det_en_i(det_en_i),
    .mode_i(mode_i), .clk_div_i(clk_div_i), .hs_thr_i(hs_thr_i),
    .vs_thr_i(vs_thr_i), .hs_inv_i(hs_inv_i), .vs_inv_i(vs_inv_i),
    .line_tgt_i(line_tgt_i), .match_o(match_o)
  );

  always @(negedge clk_i) begin
    if (match_o) m_cnt++;
    if (match_o && prev_m) dbl++;
    prev_m <= match_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(input logic act, input int w, input int gap);
    @(negedge clk_i); te_i = act;
    idle(w);
    te_i = ~act;
    idle(gap);
  endtask

  task automatic quiesce(input logic idle_lvl);
    @(negedge clk_i);
    mode_i = 2'd0; det_en_i = 1'b0; te_i = idle_lvl;
    idle(6);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    idle(3);
    check(match_o === 1'b0, "R1 reset", int'(match_o), 0);
    rst_ni = 1'b1;
    idle(3);
    check(match_o === 1'b0, "R1 after reset", int'(match_o), 0);

    foreach (VECS[i]) begin
      quiesce(1'b0);
      hs_thr_i = VECS[i].hs_thr; vs_thr_i = VECS[i].vs_thr;
      line_tgt_i = VECS[i].tgt; mode_i = VECS[i].mode; det_en_i = VECS[i].en;
      idle(3);
      base = m_cnt;
      pulse(1'b1, int'(VECS[i].vs_w), 4);
      for (int k = 0; k < int'(VECS[i].n_hs); k++) pulse(1'b1, int'(VECS[i].hs_w), 4);
      idle(8);
      check(m_cnt - base == int'(VECS[i].exp), $sformatf("R8 table vector %0d", i),
            m_cnt - base, int'(VECS[i].exp));
    end

    // R2 latency from trailing edge
    quiesce(1'b0);
    mode_i = 2'd3; det_en_i = 1'b1;
    idle(2);
    @(negedge clk_i); te_i = 1'b1;
    idle(20);
    te_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    check(match_o === 1'b0, "R2 edge+2", int'(match_o), 0);
    @(posedge clk_i); @(negedge clk_i);
    check(match_o === 1'b1, "R2 edge+3", int'(match_o), 1);
    @(posedge clk_i); @(negedge clk_i);
    check(match_o === 1'b0, "R2 edge+4", int'(match_o), 0);

    // R5 both syncs active low
    quiesce(1'b1);
    hs_inv_i = 1'b1; vs_inv_i = 1'b1; idle(4);
    mode_i = 2'd2; det_en_i = 1'b1; line_tgt_i = 11'd2;
    idle(3);
    base = m_cnt;
    pulse(1'b0, 20, 4);
    for (int k = 0; k < 4; k++) pulse(1'b0, 4, 4);
    idle(8);
    check(m_cnt - base == 2, "R5 inverted polarity", m_cnt - base, 2);
    quiesce(1'b0);
    hs_inv_i = 1'b0; vs_inv_i = 1'b0; idle(4);

    // R6 divider: tick every 2 cycles, vertical threshold 8 ticks
    clk_div_i = 3'd1; vs_thr_i = 9'd0; mode_i = 2'd3; det_en_i = 1'b1;
    idle(3);
    base = m_cnt;
    pulse(1'b1, 20, 6);
    idle(6);
    check(m_cnt - base == 1, "R6 20 cycles is 10 ticks", m_cnt - base, 1);
    base = m_cnt;
    pulse(1'b1, 12, 6);
    idle(6);
    check(m_cnt - base == 0, "R6 12 cycles is 6 ticks", m_cnt - base, 0);
    clk_div_i = 3'd0; vs_thr_i = 9'd1;

    // R8 target at saturated count: one line match only
    quiesce(1'b0);
    hs_thr_i = 3'd0; line_tgt_i = 11'd2047; mode_i = 2'd2; det_en_i = 1'b1;
    idle(3);
    base = m_cnt;
    pulse(1'b1, 16, 3);
    for (int k = 0; k < 2050; k++) pulse(1'b1, 2, 2);
    idle(8);
    check(m_cnt - base == 2, "R8 saturated target once", m_cnt - base, 2);
    hs_thr_i = 3'd2;

    // R11 reset clears arming
    quiesce(1'b0);
    line_tgt_i = 11'd3; mode_i = 2'd2; det_en_i = 1'b1;
    idle(3);
    pulse(1'b1, 20, 4);
    rst_ni = 1'b0;
    idle(2);
    check(match_o === 1'b0, "R1 async reset", int'(match_o), 0);
    rst_ni = 1'b1;
    idle(3);
    base = m_cnt;
    for (int k = 0; k < 5; k++) pulse(1'b1, 4, 4);
    idle(8);
    check(m_cnt - base == 0, "R11 no match without vsync", m_cnt - base, 0);

    check(dbl == 0, "R1 single-cycle pulses", dbl, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule